// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block sits between an 8-bit microcontroller bus and a behavioural model of a flash array made of eight main sectors and four secondary sectors. Bytes written to the array are not stored directly. Each written byte is decoded as one step of a command sequence. A command is accepted only after a fixed two-write unlock handshake. The supported operations are byte program, sector erase, whole-array erase, erase suspend and resume, identifier read, protection-status read and a return to read mode.

Program and erase take time. A down counter, loaded from a parameter, stands in for that busy period. While an operation is running, a read does not return array contents. It returns a status byte. Bit 7 of that byte is the complement of bit 7 of the value being written, and bit 6 flips on every read. Software polls these two bits until the operation is done, and then reads the real byte.

Every access is qualified by a one-hot sector-select vector, which a separate address decoder would normally drive. A parameter mask marks sectors as protected. Protected sectors refuse program and erase.

Top module: `flash_cmd_seq`

## Requirements
- R1: A command byte is accepted only after two unlock writes: AAh to address 555h, then 55h to address AAAh. A wrong data byte or a wrong address at either unlock step returns the block to read mode, and the array does not change.
- R2: An access is ignored when `sectSel` does not have exactly one bit set. Bit i of `sectSel` selects sector i, where bits 0 to 7 are the main sectors and bits 8 to 11 are the secondary sectors. An ignored read returns 00h. After reset, every byte of every sector reads FFh.
- R3: Command A0h arms byte program. The next write to the selected sector programs the byte at address offset `addr[OFF_W-1:0]`, and the stored result is the old value AND the written data, so bits can only be cleared.
- R4: While a program or erase is busy, a read returns bits 5:0 = 0. Bit 7 is the complement of bit 7 of the target value (the target is FFh for an erase). Bit 6 alternates from one read to the next.
- R5: Command 90h enters identifier mode. In this mode, a read with A6=0, A1=0, A0=1 returns E4h. A read with A6=0, A1=1, A0=0 returns 01h when the selected sector is protected and 00h otherwise. Any other address reads 00h. A write of F0h leaves the mode.
- R6: The sequence 80h, AAh@555h, 55h@AAAh, 30h erases the sector selected on the final write to all FFh and leaves the other sectors untouched.
- R7: The same sequence with 10h in place of 30h erases every unprotected sector.
- R8: Writing B0h during a sector erase suspends it. While suspended, reads of other sectors return array data, and reads of the erasing sector return a status byte with bit 7 = 0 and bit 6 held steady. Writes other than 30h are ignored. Writing 30h resumes the erase, which then completes.
- R9: Sectors whose bit is set in `PROT_MASK` ignore program and erase, and never go busy. The default mask protects sector 11 only.
- R10: F0h written in read mode, or written after the two unlock writes, leaves the block in read mode with no command armed.
- R11: Read data is registered. Counting from the clock edge that accepts the program data write, a read sampled on edge k returns status for every k up to `PROG_CYC`, and returns the programmed byte at k = `PROG_CYC`+1.
- R12: While busy, all writes are ignored except B0h during a sector erase. In particular, B0h during a whole-array erase has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address |
| wrData | input | 8 | Write data or command byte |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read strobe, one cycle per read |
| sectSel | input | NUM_MAIN+NUM_SEC | One-hot sector select |
| rdData | output | 8 | Registered read data |

## Verification
Every read result appears on `rdData` one clock after the cycle in which `rdEn` is sampled, so the bench raises a strobe on a falling edge and samples the output on the next falling edge. The busy window has an exact length: the edge that accepts a program's data write plus `PROG_CYC` more edges. The bench counts edges from that write and takes one read on the last busy edge, where status is expected, and one read on the edge after it, where data is expected. Erase durations are not timed exactly. Erases are tracked by polling bits 7 and 6 until both are stable, and each result is then compared with a reference array kept in the bench, which applies the AND and erase rules itself.

// File: rtl/flashseq_pkg.sv
package flashseq_pkg;
  localparam int SECT_IDX_W = 4;

  typedef enum logic [2:0] {
    RD_ARRAY, RD_ID, RD_PROT, RD_STATUS, RD_ZERO
  } rdSel_e;

  typedef enum logic [3:0] {
    S_READ, S_U1, S_U2, S_PROG, S_E_U1, S_E_U2, S_E_CMD,
    S_ID, S_BUSY_PROG, S_BUSY_ERS, S_SUSP
  } state_e;

  typedef struct packed {
    logic                  commitProg;
    logic                  commitErase;
    logic                  eraseAll;
    rdSel_e                rdSel;
    logic [SECT_IDX_W-1:0] accSect;
    logic [SECT_IDX_W-1:0] opSect;
    logic [7:0]            statusByte;
  } ctlStrobes_t;
endpackage

// File: rtl/flashseq_ctrl.sv
module flashseq_ctrl
  import flashseq_pkg::*;
#(
  parameter int NUM_SECT  = 12,
  parameter int ADDR_W    = 12,
  parameter int OFF_W     = 4,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 64,
  parameter logic [NUM_SECT-1:0] PROT_MASK = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          wrData,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [NUM_SECT-1:0] sectSel,
  output ctlStrobes_t         ctl,
  output logic [OFF_W-1:0]    opOff,
  output logic [7:0]          opData
);
  localparam int CNT_MAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [ADDR_W-1:0] UNLK_A = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] UNLK_B = ADDR_W'(12'hAAA);

  state_e                stateQ, stateN;
  logic [CNT_W-1:0]      cntQ, cntN;
  logic [SECT_IDX_W-1:0] opSectQ, opSectN, accSect;
  logic [OFF_W-1:0]      opOffQ, opOffN;
  logic [7:0]            opDataQ, opDataN, statusByte;
  logic                  bulkQ, bulkN, toggleQ, flip;
  logic                  validSel, wrOk, unlockA, unlockB, accProt;
  logic                  commitProg, commitErase;
  rdSel_e                rdSel;

  function automatic logic [SECT_IDX_W-1:0] selIndex(input logic [NUM_SECT-1:0] sel);
    selIndex = '0;
    for (int i = 0; i < NUM_SECT; i++)
      if (sel[i]) selIndex = SECT_IDX_W'(i);
  endfunction

  always_comb begin
    validSel = $onehot(sectSel);
    accSect  = selIndex(sectSel);
    accProt  = PROT_MASK[accSect];
    wrOk     = wrEn && validSel;
    unlockA  = wrOk && addr == UNLK_A && wrData == 8'hAA;
    unlockB  = wrOk && addr == UNLK_B && wrData == 8'h55;
  end

  // write-side sequence decoder
  always_comb begin
    stateN = stateQ; cntN = cntQ; opSectN = opSectQ; opOffN = opOffQ;
    opDataN = opDataQ; bulkN = bulkQ; commitProg = 1'b0; commitErase = 1'b0;
    case (stateQ)
      S_READ:  if (unlockA) stateN = S_U1;
      S_U1:    if (wrOk) stateN = unlockB ? S_U2 : S_READ;
      S_U2:    if (wrOk) begin
                 case (wrData)
                   8'hA0:   stateN = S_PROG;
                   8'h80:   stateN = S_E_U1;
                   8'h90:   stateN = S_ID;
                   default: stateN = S_READ;
                 endcase
               end
      S_PROG:  if (wrOk) begin
                 stateN = S_READ;
                 if (!accProt) begin
                   opSectN = accSect; opOffN = addr[OFF_W-1:0]; opDataN = wrData;
                   cntN = CNT_W'(PROG_CYC); stateN = S_BUSY_PROG;
                 end
               end
      S_E_U1:  if (wrOk) stateN = unlockA ? S_E_U2 : S_READ;
      S_E_U2:  if (wrOk) stateN = unlockB ? S_E_CMD : S_READ;
      S_E_CMD: if (wrOk) begin
                 stateN = S_READ;
                 if ((wrData == 8'h30 && !accProt) || wrData == 8'h10) begin
                   opSectN = accSect; opDataN = 8'hFF; bulkN = (wrData == 8'h10);
                   cntN = CNT_W'(ERASE_CYC); stateN = S_BUSY_ERS;
                 end
               end
      S_ID:    if (wrOk) stateN = unlockA ? S_U1 : S_READ;
      S_BUSY_PROG: begin
                 if (cntQ == CNT_W'(1)) begin commitProg = 1'b1; stateN = S_READ; end
                 else cntN = cntQ - CNT_W'(1);
               end
      S_BUSY_ERS: begin
                 if (cntQ == CNT_W'(1)) begin commitErase = 1'b1; stateN = S_READ; end
                 else if (wrOk && wrData == 8'hB0 && !bulkQ) stateN = S_SUSP;
                 else cntN = cntQ - CNT_W'(1);
               end
      S_SUSP:  if (wrOk && wrData == 8'h30) stateN = S_BUSY_ERS;
      default: stateN = S_READ;
    endcase
  end

  // read-side selection and status byte
  always_comb begin
    rdSel = RD_ZERO; statusByte = '0; flip = 1'b0;
    if (validSel) begin
      case (stateQ)
        S_BUSY_PROG, S_BUSY_ERS: begin
          rdSel = RD_STATUS; statusByte = {~opDataQ[7], toggleQ, 6'b0}; flip = rdEn;
        end
        S_SUSP: begin
          if (accSect == opSectQ) begin
            rdSel = RD_STATUS; statusByte = {1'b0, toggleQ, 6'b0};
          end else rdSel = RD_ARRAY;
        end
        S_ID: begin
          if (!addr[6] && addr[1:0] == 2'b01)      rdSel = RD_ID;
          else if (!addr[6] && addr[1:0] == 2'b10) rdSel = RD_PROT;
          else                                     rdSel = RD_ZERO;
        end
        default: rdSel = RD_ARRAY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_READ; cntQ <= '0; opSectQ <= '0; opOffQ <= '0;
      opDataQ <= 8'hFF; bulkQ <= 1'b0; toggleQ <= 1'b0;
    end else begin
      stateQ <= stateN; cntQ <= cntN; opSectQ <= opSectN; opOffQ <= opOffN;
      opDataQ <= opDataN; bulkQ <= bulkN;
      if (flip) toggleQ <= ~toggleQ;
    end
  end

  always_comb begin
    ctl = '{commitProg: commitProg, commitErase: commitErase, eraseAll: bulkQ,
            rdSel: rdSel, accSect: accSect, opSect: opSectQ, statusByte: statusByte};
  end
  assign opOff  = opOffQ;
  assign opData = opDataQ;

  // R1
  cmd_after_unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_PROG && $past(stateQ) != S_PROG) |-> $past(stateQ) == S_U2);
  // R8
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_SUSP && $past(stateQ) == S_SUSP) |-> $stable(cntQ));
  // R12
  susp_not_bulk_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == S_SUSP |-> !bulkQ);
  // R11
  busy_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_BUSY_PROG || stateQ == S_BUSY_ERS) |-> cntQ != '0);
endmodule

// File: rtl/flashseq_datapath.sv
module flashseq_datapath
  import flashseq_pkg::*;
#(
  parameter int NUM_SECT   = 12,
  parameter int SECT_BYTES = 16,
  parameter int OFF_W      = 4,
  parameter logic [NUM_SECT-1:0] PROT_MASK = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      ctl,
  input  logic [OFF_W-1:0] accOff,
  input  logic [OFF_W-1:0] opOff,
  input  logic [7:0]       opData,
  input  logic             rdEn,
  output logic [7:0]       rdData
);
  localparam logic [7:0] ID_BYTE = 8'hE4;

  logic [7:0]          mem [NUM_SECT][SECT_BYTES];
  logic [NUM_SECT-1:0] eraseHit;

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_hit
    assign eraseHit[s] = ctl.commitErase &&
      (ctl.eraseAll ? !PROT_MASK[s] : (ctl.opSect == SECT_IDX_W'(s)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SECT; s++)
        for (int b = 0; b < SECT_BYTES; b++) mem[s][b] <= 8'hFF;
    end else begin
      for (int s = 0; s < NUM_SECT; s++)
        if (eraseHit[s])
          for (int b = 0; b < SECT_BYTES; b++) mem[s][b] <= 8'hFF;
      if (ctl.commitProg) mem[ctl.opSect][opOff] <= mem[ctl.opSect][opOff] & opData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (rdEn) begin
      case (ctl.rdSel)
        RD_ARRAY:  rdData <= mem[ctl.accSect][accOff];
        RD_ID:     rdData <= ID_BYTE;
        RD_PROT:   rdData <= {7'b0, PROT_MASK[ctl.accSect]};
        RD_STATUS: rdData <= ctl.statusByte;
        default:   rdData <= '0;
      endcase
    end
  end

  // R3
  prog_and_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commitProg |=> mem[$past(ctl.opSect)][$past(opOff)] ==
      ($past(mem[ctl.opSect][opOff]) & $past(opData)));
  // R6
  erase_ff_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.commitErase && !ctl.eraseAll) |=> mem[$past(ctl.opSect)][0] == 8'hFF);
  // R5
  id_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && ctl.rdSel == RD_ID) |=> rdData == ID_BYTE);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flashseq_pkg::*;
#(
  parameter int NUM_MAIN   = 8,
  parameter int NUM_SEC    = 4,
  parameter int SECT_BYTES = 16,
  parameter int ADDR_W     = 12,
  parameter int PROG_CYC   = 8,
  parameter int ERASE_CYC  = 64,
  parameter logic [NUM_MAIN+NUM_SEC-1:0] PROT_MASK = 12'h800
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [7:0]                  wrData,
  input  logic                        wrEn,
  input  logic                        rdEn,
  input  logic [NUM_MAIN+NUM_SEC-1:0] sectSel,
  output logic [7:0]                  rdData
);
  localparam int NUM_SECT = NUM_MAIN + NUM_SEC;
  localparam int OFF_W    = $clog2(SECT_BYTES);

  ctlStrobes_t      ctl;
  logic [OFF_W-1:0] opOff;
  logic [7:0]       opData;

  flashseq_ctrl #(
    .NUM_SECT(NUM_SECT), .ADDR_W(ADDR_W), .OFF_W(OFF_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .PROT_MASK(PROT_MASK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .sectSel(sectSel), .ctl(ctl), .opOff(opOff), .opData(opData)
  );

  flashseq_datapath #(
    .NUM_SECT(NUM_SECT), .SECT_BYTES(SECT_BYTES), .OFF_W(OFF_W), .PROT_MASK(PROT_MASK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .accOff(addr[OFF_W-1:0]),
    .opOff(opOff), .opData(opData), .rdEn(rdEn), .rdData(rdData)
  );
endmodule

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/1ps
module sim_flash_cmd_seq;
  localparam int NS = 12, SB = 16, PROG = 8, PROT_S = 11;

  logic        clk = 1'b0, rstN = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [NS-1:0] sectSel = '0;
  logic [7:0]  rdData;

  int nChecks = 0, nErr = 0;
  bit finished = 0;
  logic [7:0] refMem [NS][SB];

  always #4 clk = ~clk;

  flash_cmd_seq u0 (.clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
    .wrEn(wrEn), .rdEn(rdEn), .sectSel(sectSel), .rdData(rdData));

  function automatic logic [NS-1:0] selOf(int s);
    if (s < 0) return '0;
    if (s >= NS) return 12'h003;
    return NS'(1) << s;
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErr++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(int s, logic [11:0] a, logic [7:0] d);
    sectSel = selOf(s); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; sectSel = '0;
  endtask

  task automatic rd(int s, logic [11:0] a, output logic [7:0] r);
    sectSel = selOf(s); addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0; sectSel = '0; r = rdData;
  endtask

  task automatic unlock(int s);
    wr(s, 12'h555, 8'hAA); wr(s, 12'hAAA, 8'h55);
  endtask

  task automatic pollDone(int s, logic [11:0] a, logic [7:0] exp, string req);
    logic [7:0] r1, r2;
    bit done = 0;
    for (int n = 0; n < 500 && !done; n++) begin
      rd(s, a, r1);
      if (r1[7] == exp[7]) begin
        rd(s, a, r2);
        if (r2[6] == r1[6]) done = 1;
      end
    end
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL %s: poll timeout got %02h expected %02h", req, r1, exp);
    end
    rd(s, a, r1);
    chk(req, r1, exp);
  endtask

  task automatic progByte(int s, int o, logic [7:0] d);
    unlock(s); wr(s, 12'h555, 8'hA0); wr(s, 12'(o), d);
    if (s != PROT_S) refMem[s][o] = refMem[s][o] & d;
    pollDone(s, 12'(o), refMem[s][o], "R3");
  endtask

  task automatic eraseCmd(int s, logic [7:0] last);
    unlock(s); wr(s, 12'h555, 8'h80); unlock(s); wr(s, 12'h000, last);
  endtask

  task automatic checkAll(string req);
    logic [7:0] r;
    for (int s = 0; s < NS; s++)
      for (int o = 0; o < SB; o++) begin
        rd(s, 12'(o), r); chk(req, r, refMem[s][o]);
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nErr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, ra, rb;
    for (int s = 0; s < NS; s++) for (int o = 0; o < SB; o++) refMem[s][o] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2: reset contents and unqualified reads
    rd(0, 12'h000, r);  chk("R2 reset", r, 8'hFF);
    rd(11, 12'h00F, r); chk("R2 reset", r, 8'hFF);
    rd(-1, 12'h000, r); chk("R2 no select", r, 8'h00);
    rd(99, 12'h000, r); chk("R2 two selects", r, 8'h00);

    // R11 / R4: exact busy window of a program
    unlock(0); wr(0, 12'h555, 8'hA0); wr(0, 12'h003, 8'h5A);
    rd(0, 12'h003, ra);                       // edge 1
    chk("R4 bit7", {7'b0, ra[7]}, 8'h01);
    chk("R4 low bits", {2'b0, ra[5:0]}, 8'h00);
    rd(0, 12'h003, rb);                       // edge 2
    chk("R4 toggle", {7'b0, rb[6]}, {7'b0, ~ra[6]});
    repeat (PROG - 3) @(negedge clk);
    rd(0, 12'h003, r);                        // edge PROG
    chk("R11 still busy", {r[7], r[5:0]}, 7'h40);
    rd(0, 12'h003, r);                        // edge PROG+1
    chk("R11 data", r, 8'h5A);
    refMem[0][3] = 8'h5A;

    // R3 / R9: program sweep over every byte, then an AND pass
    for (int s = 0; s < NS; s++)
      for (int o = 0; o < SB; o++)
        progByte(s, o, 8'(s * 37 + o * 11) ^ 8'h5A);
    for (int s = 0; s < 3; s++)
      for (int o = 0; o < SB; o++)
        progByte(s, o, 8'(o * 29) ^ 8'hC3);
    checkAll("R3");

    // R9: protected sector does not go busy
    unlock(PROT_S); wr(PROT_S, 12'h555, 8'hA0); wr(PROT_S, 12'h000, 8'h00);
    rd(PROT_S, 12'h000, r); chk("R9 protected program", r, 8'hFF);

    // R1: broken unlock sequences
    wr(6, 12'h555, 8'hAA); wr(6, 12'hAAA, 8'h54); wr(6, 12'h555, 8'hA0); wr(6, 12'h002, 8'h00);
    rd(6, 12'h002, r); chk("R1 wrong data", r, refMem[6][2]);
    wr(6, 12'h555, 8'hAA); wr(6, 12'hAAB, 8'h55); wr(6, 12'h555, 8'hA0); wr(6, 12'h002, 8'h00);
    rd(6, 12'h002, r); chk("R1 wrong address", r, refMem[6][2]);
    // R2: unlock write without a select is ignored
    wr(-1, 12'h555, 8'hAA); wr(6, 12'hAAA, 8'h55); wr(6, 12'h555, 8'hA0); wr(6, 12'h002, 8'h00);
    rd(6, 12'h002, r); chk("R2 unselected write", r, refMem[6][2]);

    // R10: reset after unlock
    unlock(6); wr(6, 12'h555, 8'hF0); wr(6, 12'h002, 8'h00);
    rd(6, 12'h002, r); chk("R10 reset cmd", r, refMem[6][2]);

    // R5: identifier mode
    unlock(0); wr(0, 12'h555, 8'h90);
    rd(0, 12'h001, r);  chk("R5 id", r, 8'hE4);
    rd(PROT_S, 12'h002, r); chk("R5 prot set", r, 8'h01);
    rd(0, 12'h002, r);  chk("R5 prot clear", r, 8'h00);
    rd(0, 12'h041, r);  chk("R5 other addr", r, 8'h00);
    wr(0, 12'h000, 8'hF0);
    rd(0, 12'h003, r);  chk("R5 exit", r, refMem[0][3]);

    // R6: sector erase with status polling
    eraseCmd(2, 8'h30);
    rd(2, 12'h000, r); chk("R4 erase bit7", {7'b0, r[7]}, 8'h00);
    for (int o = 0; o < SB; o++) refMem[2][o] = 8'hFF;
    pollDone(2, 12'h000, 8'hFF, "R6");
    checkAll("R6");

    // R8: suspend and resume
    eraseCmd(4, 8'h30);
    repeat (5) @(negedge clk);
    wr(4, 12'h000, 8'hB0);
    rd(5, 12'h003, r);  chk("R8 other sector", r, refMem[5][3]);
    rd(4, 12'h000, ra); rd(4, 12'h000, rb);
    chk("R8 susp bit7", {7'b0, ra[7]}, 8'h00);
    chk("R8 bit6 held", {7'b0, rb[6]}, {7'b0, ra[6]});
    wr(5, 12'h001, 8'h00);
    rd(5, 12'h001, r);  chk("R8 write ignored", r, refMem[5][1]);
    wr(4, 12'h000, 8'h30);
    for (int o = 0; o < SB; o++) refMem[4][o] = 8'hFF;
    pollDone(4, 12'h000, 8'hFF, "R8");
    checkAll("R8");

    // R12: write during program busy is ignored
    unlock(1); wr(1, 12'h555, 8'hA0); wr(1, 12'h004, 8'h0F);
    wr(1, 12'h007, 8'h00);
    refMem[1][4] = refMem[1][4] & 8'h0F;
    pollDone(1, 12'h004, refMem[1][4], "R12");
    rd(1, 12'h007, r); chk("R12 busy write", r, refMem[1][7]);

    // R7 / R12: bulk erase, B0 cannot suspend it
    eraseCmd(0, 8'h10);
    wr(0, 12'h000, 8'hB0);
    for (int s = 0; s < NS; s++)
      if (s != PROT_S) for (int o = 0; o < SB; o++) refMem[s][o] = 8'hFF;
    pollDone(0, 12'h000, 8'hFF, "R7");
    checkAll("R7");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule